// File: doc/BRIEF.md
# Period-Tracking FM Demodulator

This block recovers the modulating signal from a frequency-modulated square wave using only clocked logic. The input is first reduced to a single synchronous pulse for each rising edge. A local oscillator, built as a down-counter, reloads from a period register. Every input pulse is compared with the oscillator's terminal count, and the result is a one-step correction of that register. The register therefore follows the period of the input, measured in clock cycles, and it is itself the demodulated output word.

The loop works on period, not on phase. Each correction moves the oscillator by exactly one clock cycle. The usable range is set only by the width of the period register. There is no free-running rest frequency: after reset the oscillator waits for the first input edge, and only then starts comparing. Each input pulse restarts the oscillator, so the two stay edge-aligned once they match. A lock flag reports a run of consecutive input cycles that needed no correction. A single enable input freezes every register in the block.

Top module: `fm_period_tracker`

The comparator has three states:
- `ST_ACQUIRE` waits for the first input pulse after reset and moves to `ST_ARMED` on that pulse.
- `ST_ARMED` means an input cycle is open and the oscillator has not yet expired. A terminal count without a pulse moves it to `ST_EXPIRED`. A pulse, with or without a terminal count, keeps it in `ST_ARMED`.
- `ST_EXPIRED` means the oscillator ran out before the input edge arrived. A pulse returns it to `ST_ARMED`. A further terminal count alone keeps it in `ST_EXPIRED`.

## Requirements
- R1: During and after reset, `period_out` holds mid-scale, 2^(PW-1) (128 for the default PW of 8), and `locked` is 0.
- R2: Each rising edge of `fm_in` produces exactly one internal pulse, however long the high level lasts. Until the first rising edge after reset, no correction occurs, so `period_out` stays at mid-scale.
- R3: If an input pulse arrives before the oscillator's terminal count, `period_out` decreases by one. An input of constant period T clocks that is shorter than `period_out`+1 drives `period_out` down to T-1.
- R4: If the terminal count comes before the input pulse, `period_out` increases by one, and by one more for each further terminal count before that pulse. An input of period T clocks that is longer than `period_out`+1 drives `period_out` up to T-1.
- R5: If the pulse and the terminal count fall in the same cycle, there is no correction. An input of period T = `period_out`+1 leaves `period_out` unchanged, which means zero static phase error.
- R6: `period_out` changes by at most one per clock.
- R7: `period_out` saturates: it never moves from all-ones to zero, or from zero to all-ones. With no input edges it climbs to all-ones and stays there.
- R8: `locked` rises once LOCK_RUN consecutive input cycles have ended in a match (R5). It falls in the same cycle as any correction.
- R9: While `clk_en` is 0, `period_out` and `locked` hold their values, and edges on `fm_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Global enable; 0 freezes all state |
| fm_in | input | 1 | Raw frequency-modulated input bit |
| period_out | output | PW | Tracked oscillator period minus one, in clocks; the demodulated output |
| locked | output | 1 | High after LOCK_RUN consecutive uncorrected input cycles |

## Verification
A rising edge on `fm_in`, set up before clock edge k, is captured in the pulse register at edge k. The comparator acts on it at edge k+1, and `period_out`, `locked` and the oscillator reload all update at that edge. The matching terminal count falls period+1 edges after that reload. The bench drives `fm_in` at falling clock edges and samples only at falling edges. Each waveform task returns just before the next rising input edge, so every check sees the outcome of the most recent complete input cycle and no partially handled one. Convergence checks run many more input cycles than the number of one-step corrections needed to reach T-1.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    // Correction requested by the comparator for the current clock
    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_DEC  = 2'd1,
        CORR_INC  = 2'd2
    } corr_e;

    // Comparator states
    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_ARMED   = 2'd1,
        ST_EXPIRED = 2'd2
    } trk_state_e;

endpackage

// File: rtl/fmt_edge_pulse.sv
// Rising-edge detector followed by a resynchronising flop: one pulse per edge
module fmt_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw_in,
    output logic pulse
);

    logic prev_q;
    logic edge_raw;

    assign edge_raw = raw_in & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pulse  <= 1'b0;
        end else if (en) begin
            prev_q <= raw_in;
            pulse  <= edge_raw;
        end
    end

endmodule

// File: rtl/fmt_osc_counter.sv
// Local oscillator: down-counter reloaded from the period register
module fmt_osc_counter #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [PW-1:0] reload_val,
    output logic          tc
);

    logic [PW-1:0] cnt_q;

    assign tc = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            if (load || tc) begin
                cnt_q <= reload_val;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/fmt_track_fsm.sv
// Compares input pulses with terminal counts and issues corrections
module fmt_track_fsm
    import fmt_pkg::*;
#(
    parameter int LOCK_RUN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  pulse,
    input  logic  tc,
    output corr_e corr,
    output logic  locked
);

    localparam int             RW      = $clog2(LOCK_RUN + 1);
    localparam logic [RW-1:0]  RUN_MAX = RW'(LOCK_RUN);

    trk_state_e    state_q;
    trk_state_e    state_d;
    logic          match;
    logic [RW-1:0] run_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
        end else if (en) begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: if (pulse)        state_d = ST_ARMED;
            ST_ARMED:   if (tc && !pulse) state_d = ST_EXPIRED;
            ST_EXPIRED: if (pulse)        state_d = ST_ARMED;
            default:                      state_d = ST_ACQUIRE;
        endcase
    end

    // Outputs
    always_comb begin
        corr  = CORR_NONE;
        match = 1'b0;
        unique case (state_q)
            ST_ACQUIRE: corr = CORR_NONE;
            ST_ARMED: begin
                if (pulse && !tc)      corr  = CORR_DEC;
                else if (tc && !pulse) corr  = CORR_INC;
                else if (tc && pulse)  match = 1'b1;
            end
            ST_EXPIRED: if (tc && !pulse) corr = CORR_INC;
            default:    corr = CORR_NONE;
        endcase
    end

    // Run of uncorrected input cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (en) begin
            if (corr != CORR_NONE) begin
                run_q <= '0;
            end else if (match && (run_q != RUN_MAX)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign locked = (run_q == RUN_MAX);

endmodule

// File: rtl/fmt_period_integ.sv
// Saturating integrator of the corrections; its value is the output word
module fmt_period_integ
    import fmt_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  corr_e         corr,
    output logic [PW-1:0] period
);

    localparam logic [PW-1:0] MID = {1'b1, {(PW-1){1'b0}}};
    localparam logic [PW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= MID;
        end else if (en) begin
            unique case (corr)
                CORR_INC:  if (period != TOP) period <= period + 1'b1;
                CORR_DEC:  if (period != '0)  period <= period - 1'b1;
                CORR_NONE: period <= period;
                default:   period <= period;
            endcase
        end
    end

endmodule

// File: rtl/fm_period_tracker.sv
module fm_period_tracker
    import fmt_pkg::*;
#(
    parameter int PW       = 8,
    parameter int LOCK_RUN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          fm_in,
    output logic [PW-1:0] period_out,
    output logic          locked
);

    logic  in_pulse;
    logic  osc_tc;
    corr_e corr;

    fmt_edge_pulse u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (clk_en),
        .raw_in (fm_in),
        .pulse  (in_pulse)
    );

    // Each input pulse restarts the oscillator so the edges stay aligned
    fmt_osc_counter #(.PW(PW)) u_osc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (clk_en),
        .load       (in_pulse),
        .reload_val (period_out),
        .tc         (osc_tc)
    );

    fmt_track_fsm #(.LOCK_RUN(LOCK_RUN)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (clk_en),
        .pulse  (in_pulse),
        .tc     (osc_tc),
        .corr   (corr),
        .locked (locked)
    );

    fmt_period_integ #(.PW(PW)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (clk_en),
        .corr   (corr),
        .period (period_out)
    );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
    parameter int PW       = 8,
    parameter int LOCK_RUN = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic [PW-1:0] period_out,
    input logic          locked
);

    localparam logic [PW-1:0] MID = {1'b1, {(PW-1){1'b0}}};
    localparam logic [PW-1:0] TOP = '1;

    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> (period_out == MID) && !locked);

    p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (period_out >= $past(period_out))
            ? ((period_out - $past(period_out)) <= PW'(1))
            : (($past(period_out) - period_out) <= PW'(1)));

    p_no_wrap_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (period_out == TOP) |=> (period_out != '0));

    p_no_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (period_out == '0) |=> (period_out != TOP));

    p_lock_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_out != $past(period_out)) |-> !locked);

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(period_out) && $stable(locked));

endmodule

bind fm_period_tracker fmt_checker #(.PW(PW), .LOCK_RUN(LOCK_RUN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .period_out (period_out),
    .locked     (locked)
);

// File: tb/tb_fm_period_tracker.sv
`timescale 1ns/1ps
module tb_fm_period_tracker;

    localparam int PW       = 8;
    localparam int LOCK_RUN = 4;
    localparam int MID      = 1 << (PW - 1);
    localparam int TOPV     = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en;
    logic          fm_in;
    logic [PW-1:0] period_out;
    logic          locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // R6 step monitor and R9 freeze monitor
    bit            step_mon = 0;
    bit            step_bad = 0;
    logic [PW-1:0] prev_p;
    bit            frz_mon = 0;
    bit            frz_bad = 0;
    logic [PW-1:0] snap_p;
    logic          snap_l;

    always #5 clk = ~clk;

    fm_period_tracker #(.PW(PW), .LOCK_RUN(LOCK_RUN)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .fm_in      (fm_in),
        .period_out (period_out),
        .locked     (locked)
    );

    always @(negedge clk) begin
        if (step_mon) begin
            if ((int'(period_out) - int'(prev_p) > 1) ||
                (int'(prev_p) - int'(period_out) > 1)) step_bad = 1;
        end
        prev_p = period_out;
        if (frz_mon && ((period_out != snap_p) || (locked != snap_l))) frz_bad = 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_sq(input int hi, input int lo, input int n);
        for (int i = 0; i < n; i++) begin
            fm_in = 1'b1;
            repeat (hi) @(negedge clk);
            fm_in = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; clk_en = 1'b1; fm_in = 1'b0;
        repeat (4) @(negedge clk);
        check(period_out == PW'(MID), "R1 period in reset", period_out, MID);
        check(locked == 1'b0, "R1 locked in reset", locked, 0);
        rst_n = 1'b1;
        @(negedge clk);
        step_mon = 1;
    endtask

    task automatic t_acquire;
        repeat (400) @(negedge clk);
        check(period_out == PW'(MID), "R2 no correction before first edge", period_out, MID);
        check(locked == 1'b0, "R2 not locked before first edge", locked, 0);
    endtask

    // Period 129 matches the reset value 128: no corrections, lock after LOCK_RUN matches
    task automatic t_lock_count;
        drive_sq(64, 65, 1);
        for (int k = 1; k < LOCK_RUN; k++) begin
            drive_sq(64, 65, 1);
            check(locked == 1'b0, "R8 lock not yet", locked, 0);
            check(period_out == PW'(MID), "R5 matched period held", period_out, MID);
        end
        drive_sq(64, 65, 1);
        check(locked == 1'b1, "R8 lock after run", locked, 1);
        check(period_out == PW'(MID), "R5 zero phase error", period_out, MID);
    endtask

    task automatic t_track_down;
        drive_sq(50, 50, 60);
        check(period_out == PW'(99), "R3 converge to T-1", period_out, 99);
        check(locked == 1'b1, "R3 locked after descent", locked, 1);
    endtask

    task automatic t_track_up;
        drive_sq(80, 80, 80);
        check(period_out == PW'(159), "R4 converge to T-1", period_out, 159);
        check(locked == 1'b1, "R4 locked after ascent", locked, 1);
    endtask

    task automatic t_lock_drop;
        drive_sq(75, 75, 2);
        check(period_out == PW'(158), "R8 one early cycle", period_out, 158);
        check(locked == 1'b0, "R8 lock dropped on correction", locked, 0);
        drive_sq(75, 75, 30);
        check(period_out == PW'(149), "R3 reconverge", period_out, 149);
        check(locked == 1'b1, "R8 relocked", locked, 1);
    endtask

    task automatic t_freeze;
        clk_en = 1'b0;
        @(negedge clk);
        snap_p = period_out; snap_l = locked; frz_bad = 0; frz_mon = 1;
        drive_sq(20, 30, 8);
        frz_mon = 0;
        check(!frz_bad, "R9 outputs frozen", int'(frz_bad), 0);
        check(locked == 1'b1, "R9 lock kept while frozen", locked, 1);
        clk_en = 1'b1;
    endtask

    task automatic t_saturate;
        fm_in = 1'b0;
        repeat (30000) @(negedge clk);
        check(period_out == PW'(TOPV), "R7 reach all-ones", period_out, TOPV);
        check(locked == 1'b0, "R4 no lock without input", locked, 0);
        repeat (600) @(negedge clk);
        check(period_out == PW'(TOPV), "R7 hold all-ones", period_out, TOPV);
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_lock_count();
        t_track_down();
        t_track_up();
        t_lock_drop();
        t_freeze();
        t_saturate();
        check(!step_bad, "R6 unit step", int'(step_bad), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule